// File: doc/BRIEF.md
# Linear to Tiled Address Translator

This block turns a 32-bit pixel coordinate into the byte offset of that pixel inside a surface stored in one of four layouts. The layouts are plain row-major, a wide tile 512 bytes across and 8 rows high, a tall tile of 16-byte columns 32 rows high, and a 128-byte by 32-row tile built from 64-byte subtiles whose order is permuted. Each tile holds 4096 bytes. For the wide and tall layouts, bit 6 of the result can be flipped by an XOR of higher offset bits. This matches how some memory controllers spread accesses across channels.

A request carries the column `x` in pixels, the row `y`, the row pitch in bytes and a layout code. It enters on a valid/ready handshake and passes through a three-stage pipeline. The offset leaves on a second valid/ready handshake in request order. Each of the two swizzle-capable layouts has its own swizzle selector. The row pitch must be a multiple of the tile width of the chosen layout. With any other pitch the result is undefined.

Top module: `tile_addr_xlat`

## Requirements
- R1: Layout code 0 (row-major) returns `y*pitch + 4*x` and never applies a bit-6 flip.
- R2: Layout code 1 (wide tile) returns `(y/8)*pitch*8 + (y%8)*512 + (xb/512)*4096 + xb%512`, where `xb = 4*x`.
- R3: Layout code 2 (tall tile) returns `(y/32)*pitch*32 + (y%32)*16 + (xb/16)*512 + xb%16`.
- R4: Layout code 3 (subtiled tile) returns `(y/32)*pitch*32 + (xb/128)*4096 + q*64 + (y%4)*16 + xb%16`. Here `s = ((y%32)/4)*8 + (xb%128)/16`, and `q` is `s` with its bits 2 and 3 exchanged (for example, s=9 gives q=5).
- R5: Layout code 3 never applies a bit-6 flip, whatever the two swizzle selectors hold.
- R6: The swizzle code sets bit 6 to its own value XORed with the following bits of the unswizzled offset: 0 none, 1 bit 9, 2 bits 9 and 10, 3 bits 9 and 11, 4 bits 9, 10 and 11. Codes 5 to 7 act as none. Layout 1 uses `swz_wide`, layout 2 uses `swz_tall`.
- R7: With `out_ready` held high, a request accepted on one rising edge shows `out_valid` after the third rising edge, counting the accepting edge. `out_valid` is still low after the second edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_offset` and `out_valid` hold and `in_ready` is low. When `out_valid` is low, `in_ready` is high. Every accepted request yields exactly one result, in order.
- R9: During and right after a synchronous active-low reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_x | input | X_W (12) | Pixel column |
| in_y | input | Y_W (12) | Pixel row |
| in_pitch | input | PITCH_W (16) | Row pitch in bytes |
| in_layout | input | 2 | 0 row-major, 1 wide tile, 2 tall tile, 3 subtiled tile |
| swz_wide | input | 3 | Swizzle code for layout 1 |
| swz_tall | input | 3 | Swizzle code for layout 2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_offset | output | OFF_W (32) | Byte offset of the pixel |

## Verification
A wrong subtile permutation or a wrong tile split shows up at once in the first result of the affected layout. The bench compares each result against a model built on integer division. A bit-6 flip applied to the wrong layout, or driven by the wrong selector, appears as a mismatch confined to bit 6 of that request's offset. A broken stall path shows up within one cycle of a stall: the offset moves while held, `in_ready` rises while the output is blocked, or a result is lost or duplicated, which breaks the order of the scoreboard queue.

// File: rtl/tile_xlat_pkg.sv
// Shared encodings for the tiled address translator.
// Assumes 32-bit pixels and 4096-byte tiles.
package tile_xlat_pkg;

    typedef enum logic [1:0] {
        LAY_ROWMAJ = 2'd0,
        LAY_WIDE   = 2'd1,
        LAY_TALL   = 2'd2,
        LAY_SUBT   = 2'd3
    } layout_e;

    localparam logic [2:0] SWZ_OFF      = 3'd0;
    localparam logic [2:0] SWZ_B9       = 3'd1;
    localparam logic [2:0] SWZ_B9_10    = 3'd2;
    localparam logic [2:0] SWZ_B9_11    = 3'd3;
    localparam logic [2:0] SWZ_B9_10_11 = 3'd4;

    localparam int PIX_SHIFT  = 2;   // 4 bytes per pixel
    localparam int TILE_SHIFT = 12;  // 4096 bytes per tile

endpackage

// File: rtl/subtile_perm.sv
// Self-inverse subtile index permutation: exchanges bit LO_BIT with
// bit LO_BIT+1 and passes all other bits through.
// Assumes IDX_W > LO_BIT+1.
module subtile_perm #(
    parameter int IDX_W  = 6,
    parameter int LO_BIT = 2
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] perm_o
);

    // Build the permuted index bit by bit.
    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        if (i == LO_BIT) begin : g_lo
            assign perm_o[i] = idx_i[i+1];
        end else if (i == LO_BIT + 1) begin : g_hi
            assign perm_o[i] = idx_i[i-1];
        end else begin : g_pass
            assign perm_o[i] = idx_i[i];
        end
    end

    // Check that applying the map twice returns the original index.
    always_comb begin
        if (!$isunknown(idx_i)) begin
            AST_PERM_SELF_INVERSE: assert ({perm_o[IDX_W-1:LO_BIT+2], perm_o[LO_BIT], perm_o[LO_BIT+1],
                                             perm_o[LO_BIT-1:0]} == idx_i)
                else $error("subtile map is not self-inverse"); // R4
        end
    end

endmodule

// File: rtl/tile_geom.sv
// Layout geometry: splits a pixel position into a row-aligned y
// (multiplied by the pitch downstream) and an in-band offset that
// already includes the tile column and in-tile position.
// Assumes Y_W >= 5 and OFF_W >= 16.
module tile_geom
    import tile_xlat_pkg::*;
#(
    parameter int X_W   = 12,
    parameter int Y_W   = 12,
    parameter int OFF_W = 32
) (
    input  logic [X_W-1:0]   x_i,
    input  logic [Y_W-1:0]   y_i,
    input  layout_e          layout_i,
    output logic [Y_W-1:0]   yrow_o,
    output logic [OFF_W-1:0] band_o
);

    localparam logic [OFF_W-1:0] M511 = OFF_W'(511);
    localparam logic [OFF_W-1:0] M15  = OFF_W'(15);

    logic [OFF_W-1:0] xb;
    logic [5:0]       sub_raw;
    logic [5:0]       sub_perm;

    // Byte column of the pixel.
    assign xb = OFF_W'(x_i) << PIX_SHIFT;

    // Raw subtile index inside a subtiled tile: subtile row, then column.
    assign sub_raw = {y_i[4:2], xb[6:4]};

    subtile_perm #(.IDX_W(6), .LO_BIT(2)) u_perm (
        .idx_i  (sub_raw),
        .perm_o (sub_perm)
    );

    // Select the row alignment and in-band offset for the chosen layout.
    always_comb begin
        unique case (layout_i)
            LAY_WIDE: begin
                yrow_o = {y_i[Y_W-1:3], 3'b000};
                band_o = (OFF_W'(y_i[2:0]) << 9) + ((xb >> 9) << TILE_SHIFT) + (xb & M511);
            end
            LAY_TALL: begin
                yrow_o = {y_i[Y_W-1:5], 5'b00000};
                band_o = (OFF_W'(y_i[4:0]) << 4) + ((xb >> 4) << 9) + (xb & M15);
            end
            LAY_SUBT: begin
                yrow_o = {y_i[Y_W-1:5], 5'b00000};
                band_o = ((xb >> 7) << TILE_SHIFT) + (OFF_W'(sub_perm) << 6)
                       + (OFF_W'(y_i[1:0]) << 4) + (xb & M15);
            end
            default: begin
                yrow_o = y_i;
                band_o = xb;
            end
        endcase
    end

endmodule

// File: rtl/bit6_swz.sv
// Bit-6 swizzle: flips bit 6 by the parity of a code-selected subset
// of bits 9, 10 and 11 of the incoming offset. Unused codes pass through.
// Assumes OFF_W >= 12.
module bit6_swz
    import tile_xlat_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [2:0]       code_i,
    output logic [OFF_W-1:0] off_o
);

    logic flip;

    // Parity of the selected high bits.
    always_comb begin
        unique case (code_i)
            SWZ_B9:       flip = off_i[9];
            SWZ_B9_10:    flip = off_i[9] ^ off_i[10];
            SWZ_B9_11:    flip = off_i[9] ^ off_i[11];
            SWZ_B9_10_11: flip = off_i[9] ^ off_i[10] ^ off_i[11];
            default:      flip = 1'b0;
        endcase
    end

    // Apply the flip to bit 6 only.
    assign off_o = off_i ^ (OFF_W'(flip) << 6);

    // Only bit 6 may differ between input and output.
    always_comb begin
        if (!$isunknown(off_i) && !$isunknown(code_i)) begin
            AST_SWZ_BIT6_ONLY: assert (((off_o ^ off_i) & ~(OFF_W'(1) << 6)) == '0)
                else $error("swizzle touched a bit other than 6"); // R6
        end
    end

endmodule

// File: rtl/tile_addr_xlat.sv
// Linear to tiled address translator, top level.
// Stage 1 registers the layout geometry and swizzle choice, stage 2 the
// pitch product sum, stage 3 the swizzled offset. One global enable stalls
// all stages when the output is blocked.
// Assumes the pitch is a multiple of the tile width of the layout in use.
module tile_addr_xlat
    import tile_xlat_pkg::*;
#(
    parameter int X_W     = 12,
    parameter int Y_W     = 12,
    parameter int PITCH_W = 16,
    parameter int OFF_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [X_W-1:0]     in_x,
    input  logic [Y_W-1:0]     in_y,
    input  logic [PITCH_W-1:0] in_pitch,
    input  logic [1:0]         in_layout,
    input  logic [2:0]         swz_wide,
    input  logic [2:0]         swz_tall,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OFF_W-1:0]   out_offset
);

    localparam int STAGES = 3;

    logic [STAGES-1:0]  vld;
    logic               adv;

    layout_e            lay_in;
    logic [Y_W-1:0]     g_yrow;
    logic [OFF_W-1:0]   g_band;
    logic [2:0]         swz_sel;

    logic [Y_W-1:0]     s1_yrow;
    logic [PITCH_W-1:0] s1_pitch;
    logic [OFF_W-1:0]   s1_band;
    logic [2:0]         s1_swz;
    layout_e            s1_lay;

    logic [OFF_W-1:0]   s2_off;
    logic [2:0]         s2_swz;
    logic [OFF_W-1:0]   s2_swizzled;

    logic [OFF_W-1:0]   s3_off;

    // Global advance: the pipe moves unless a result waits at the output.
    assign adv      = !vld[STAGES-1] || out_ready;
    assign in_ready = adv;

    assign lay_in = layout_e'(in_layout);

    tile_geom #(.X_W(X_W), .Y_W(Y_W), .OFF_W(OFF_W)) u_geom (
        .x_i      (in_x),
        .y_i      (in_y),
        .layout_i (lay_in),
        .yrow_o   (g_yrow),
        .band_o   (g_band)
    );

    // Pick the swizzle selector that belongs to the layout.
    always_comb begin
        unique case (lay_in)
            LAY_WIDE: swz_sel = swz_wide;
            LAY_TALL: swz_sel = swz_tall;
            default:  swz_sel = SWZ_OFF;
        endcase
    end

    // Valid bits shift along the pipe when it advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (adv) begin
            vld <= {vld[STAGES-2:0], in_valid};
        end
    end

    // Stage 1: capture geometry terms.
    always_ff @(posedge clk) begin
        if (adv) begin
            s1_yrow  <= g_yrow;
            s1_pitch <= in_pitch;
            s1_band  <= g_band;
            s1_swz   <= swz_sel;
            s1_lay   <= lay_in;
        end
    end

    // Stage 2: add the row-band product to the in-band offset.
    always_ff @(posedge clk) begin
        if (adv) begin
            s2_off <= OFF_W'(s1_yrow) * OFF_W'(s1_pitch) + s1_band;
            s2_swz <= s1_swz;
        end
    end

    bit6_swz #(.OFF_W(OFF_W)) u_swz (
        .off_i  (s2_off),
        .code_i (s2_swz),
        .off_o  (s2_swizzled)
    );

    // Stage 3: register the swizzled result.
    always_ff @(posedge clk) begin
        if (adv) begin
            s3_off <= s2_swizzled;
        end
    end

    assign out_valid  = vld[STAGES-1];
    assign out_offset = s3_off;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_offset))
        else $error("result changed while stalled"); // R8

    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready)
        else $error("input blocked with empty output"); // R8

    AST_SUBT_NO_SWZ: assert property (@(posedge clk) disable iff (!rst_n)
        vld[0] && s1_lay == LAY_SUBT |-> s1_swz == SWZ_OFF)
        else $error("subtiled layout carries a swizzle"); // R5

    AST_ROWMAJ_NO_SWZ: assert property (@(posedge clk) disable iff (!rst_n)
        vld[0] && s1_lay == LAY_ROWMAJ |-> s1_swz == SWZ_OFF)
        else $error("row-major layout carries a swizzle"); // R1

endmodule

// File: tb/sim_tile_addr_xlat.sv
`timescale 1ns/1ps
module sim_tile_addr_xlat;

    localparam int X_W = 12, Y_W = 12, PITCH_W = 16, OFF_W = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [X_W-1:0]     in_x = '0;
    logic [Y_W-1:0]     in_y = '0;
    logic [PITCH_W-1:0] in_pitch = '0;
    logic [1:0]         in_layout = '0;
    logic [2:0]         swz_wide = '0;
    logic [2:0]         swz_tall = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [OFF_W-1:0]   out_offset;

    int errors = 0;
    int checks = 0;
    bit stall_mode = 1'b0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk; // 50 MHz

    tile_addr_xlat #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .OFF_W(OFF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_pitch(in_pitch), .in_layout(in_layout),
        .swz_wide(swz_wide), .swz_tall(swz_tall), .out_valid(out_valid),
        .out_ready(out_ready), .out_offset(out_offset)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference offset computed from the requirement formulas.
    function automatic logic [31:0] model(input int x, input int y, input int p,
                                          input int lay, input int sw_w, input int sw_t);
        int xb, v, sw, tr, tc, s, q, f;
        xb = x * 4;
        sw = 0;
        case (lay)
            1: begin
                v = (y / 8) * p * 8 + (y % 8) * 512 + (xb / 512) * 4096 + xb % 512;
                sw = sw_w;
            end
            2: begin
                v = (y / 32) * p * 32 + (y % 32) * 16 + (xb / 16) * 512 + xb % 16;
                sw = sw_t;
            end
            3: begin
                tr = y % 32;
                tc = xb % 128;
                s = (tr / 4) * 8 + tc / 16;
                q = (s & ~12) | ((s >> 1) & 4) | ((s << 1) & 8);
                v = (y / 32) * p * 32 + (xb / 128) * 4096 + q * 64 + (tr % 4) * 16 + tc % 16;
            end
            default: v = y * p + xb;
        endcase
        case (sw)
            1: f = (v >> 9) & 1;
            2: f = ((v >> 9) ^ (v >> 10)) & 1;
            3: f = ((v >> 9) ^ (v >> 11)) & 1;
            4: f = ((v >> 9) ^ (v >> 10) ^ (v >> 11)) & 1;
            default: f = 0;
        endcase
        return 32'(v ^ (f << 6));
    endfunction

    // Driver: present one request, wait for acceptance, push the expectation.
    task automatic send(input int x, input int y, input int p, input int lay,
                        input int sw_w, input int sw_t, input logic [31:0] exp, input string tag);
        @(negedge clk);
        #2;
        in_x = X_W'(x); in_y = Y_W'(y); in_pitch = PITCH_W'(p);
        in_layout = 2'(lay); swz_wide = 3'(sw_w); swz_tall = 3'(sw_t);
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #3;
        end
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic send_m(input int x, input int y, input int p, input int lay,
                          input int sw_w, input int sw_t, input string tag);
        send(x, y, p, lay, sw_w, sw_t, model(x, y, p, lay, sw_w, sw_t), tag);
    endtask

    // Monitor: drives out_ready, checks stalls and pops the scoreboard.
    initial begin : monitor
        bit held;
        logic [31:0] held_off;
        logic [31:0] e;
        string t;
        held = 1'b0;
        held_off = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (held) begin
                    check(out_valid === 1'b1, "R8 valid held", longint'(out_valid), 1);
                    check(out_offset === held_off, "R8 offset held", longint'(out_offset), longint'(held_off));
                end
                out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
                #1;
                held = out_valid && !out_ready;
                held_off = out_offset;
                if (held) check(in_ready === 1'b0, "R8 in_ready low when blocked", longint'(in_ready), 0);
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected result", longint'(out_offset), -1);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_offset === e, t, longint'(out_offset), longint'(e));
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(20ns * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R9 out_valid in reset", longint'(out_valid), 0);
        check(in_ready === 1'b1, "R9 in_ready in reset", longint'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R9 out_valid after reset", longint'(out_valid), 0);
        check(in_ready === 1'b1, "R9 in_ready after reset", longint'(in_ready), 1);

        // R7 latency with the output always ready.
        @(negedge clk);
        #2;
        in_x = 12'd1; in_y = 12'd0; in_pitch = 16'd512; in_layout = 2'd0;
        swz_wide = 3'd0; swz_tall = 3'd0; in_valid = 1'b1;
        exp_q.push_back(32'd4);
        tag_q.push_back("R7 latency item");
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R7 not valid after edge 1", longint'(out_valid), 0);
        @(negedge clk);
        check(out_valid === 1'b0, "R7 not valid after edge 2", longint'(out_valid), 0);
        @(negedge clk);
        check(out_valid === 1'b1, "R7 valid after edge 3", longint'(out_valid), 1);
        repeat (2) @(negedge clk);

        // Directed values with literal expectations.
        send(5, 3, 2048, 0, 4, 4, 32'd6164, "R1 row-major");
        send(130, 9, 2048, 1, 0, 0, 32'd21000, "R2 wide tile");
        send(5, 33, 1024, 2, 0, 0, 32'd33300, "R3 tall tile");
        send(4, 4, 512, 3, 0, 0, 32'd320, "R4 subtile 9 maps to 5");
        send(4, 4, 512, 3, 4, 4, 32'd320, "R5 subtiled ignores swizzle");
        send(0, 1, 512, 1, 1, 0, 32'd576, "R6 code1 bit9");
        send(0, 3, 512, 1, 2, 0, 32'd1536, "R6 code2 bit9^bit10");
        send(0, 1, 512, 1, 3, 0, 32'd576, "R6 code3 bit9^bit11");
        send(0, 7, 512, 1, 4, 0, 32'd3648, "R6 code4 bit9^bit10^bit11");
        send(0, 1, 512, 1, 5, 0, 32'd512, "R6 code5 acts as none");
        send(4, 0, 512, 2, 0, 1, 32'd576, "R6 tall uses its own selector");
        send(4, 0, 512, 2, 1, 0, 32'd512, "R6 tall ignores wide selector");
        send(1, 1, 512, 0, 1, 1, 32'd516, "R1 row-major unswizzled");

        // Randomised traffic with back-pressure.
        stall_mode = 1'b1;
        for (int i = 0; i < 400; i++) begin
            int lay, p, x, y;
            lay = int'($urandom % 4);
            p = 512 * (1 + int'($urandom % 16));
            x = int'($urandom % 4096);
            y = int'($urandom % 4096);
            send_m(x, y, p, lay, int'($urandom % 8), int'($urandom % 8),
                   lay == 0 ? "R1 random" : lay == 1 ? "R2 random" : lay == 2 ? "R3 random" : "R4 random");
        end

        // Drain and confirm nothing was lost.
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        stall_mode = 1'b0;
        for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R8 all results delivered", longint'(exp_q.size()), 0);
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R8 no extra result", longint'(out_valid), 0);
        finish_run();
    end

endmodule